// File: doc/BRIEF.md
# Raster beam position counter

This block produces the horizontal and vertical beam position of a video raster, counted in master clock cycles. A line is made of a fixed number of dots, each a fixed number of cycles long. The block gives out the cycle position within the line, the dot position, the line number, a field bit, and a status bit that flips once per frame. It also gives one-cycle strobes on the last cycle of each line and on the last cycle of each frame. Rendering, transfer engines and interrupt logic use these outputs as their timebase.

Frame length depends on a region select that picks a 262-line or a 312-line base, and on an interlace enable. With interlace on, the field that starts with the field bit at 0 gets one extra line. With interlace off, line 240 is four cycles (one dot) short whenever the field bit is 1. The vertical limit for a frame is fixed at the frame wrap. The short-line decision for a line is fixed at the start of that line.

Top module: `beam_raster_counter`

## Requirements
- R1: Reset is synchronous and active high. It clears the cycle counter, the dot counter, the line counter, the field bit and the status bit, and it selects a full-length first line. The first frame after reset uses the base line count of the region select sampled during reset, with no extra line.
- R2: The cycle counter `hcount` increases by one on every clock within a line. `dot` equals `hcount` divided by the cycles per dot (4), rounded down.
- R3: A full line lasts 1364 cycles (341 dots), so `hcount` runs 0 to 1363. `eol` is high only on the last cycle of a line. On the following edge `hcount` and `dot` return to 0 and `vcount` advances.
- R4: With interlace off and the field bit at 1, line 240 lasts 1360 cycles (`hcount` ends at 1359, `dot` at 339).
- R5: With interlace on, every line lasts 1364 cycles, whatever the field bit.
- R6: After the last line of a frame, `vcount` returns to 0 and `field` toggles. `eof` is high only on the last cycle of the frame, which is also an `eol` cycle. `field` changes at no other time.
- R7: The frame limit is chosen at the frame wrap. It is 262 lines for `region_sel`=0 and 312 for `region_sel`=1, plus one line when `interlace_en` is 1 and the new field bit is 0. A change of `interlace_en` or `region_sel` in the middle of a frame does not change that frame's length.
- R8: `frame_toggle` inverts at every frame wrap and holds its value at all other times.
- R9: Whether a line is short is decided from `interlace_en` at the edge where that line starts. A change of `interlace_en` later in the line does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| interlace_en | input | 1 | 1 selects interlaced timing |
| region_sel | input | 1 | 0 selects the 262-line base, 1 the 312-line base |
| hcount | output | 11 | Master-cycle position within the line |
| dot | output | 9 | Dot position within the line |
| vcount | output | 9 | Line number within the frame |
| field | output | 1 | Current field bit |
| eol | output | 1 | High on the last cycle of each line |
| eof | output | 1 | High on the last cycle of each frame |
| frame_toggle | output | 1 | Status bit that inverts at every frame wrap |

## Verification
The assertions take the line to be at least two cycles long and the frame to be at least two lines. They only look at output ports, so they treat `interlace_en` and `region_sel` as free inputs that may change at any time. The bench shrinks line and frame sizes through the parameters, with a short line placed inside the shorter frame, so that every combination of region, interlace and field fits in the run. It holds the mode inputs fixed across a wrap before each measured frame, and it changes them in the middle of a frame only in the directed tests that check the latching rules.

// File: rtl/beam_pkg.sv
package beam_pkg;

    // Frame configuration captured at each frame wrap
    typedef struct packed {
        logic region;   // 0: short base count, 1: long base count
        logic extra;    // 1: one added line in this frame
    } frame_cfg_t;

    // Number of lines in a frame for a given captured configuration
    function automatic int frame_lines(input int base_a, input int base_b,
                                       input frame_cfg_t cfg);
        int n;
        n = cfg.region ? base_b : base_a;
        if (cfg.extra) n = n + 1;
        return n;
    endfunction

    // Master cycles in a line; a shortened line drops one dot
    function automatic int line_cycles(input int dots, input int cyc_per_dot,
                                       input logic shortened);
        return shortened ? (dots - 1) * cyc_per_dot : dots * cyc_per_dot;
    endfunction

endpackage

// File: rtl/beam_hcounter.sv
module beam_hcounter #(
    parameter int CYC_PER_DOT   = 4,
    parameter int DOTS_PER_LINE = 341,
    parameter int HW            = 11,
    parameter int DW            = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          short_line,
    output logic [HW-1:0] hcount,
    output logic [DW-1:0] dot,
    output logic          eol
);
    localparam int PW        = (CYC_PER_DOT > 1) ? $clog2(CYC_PER_DOT) : 1;
    localparam int FULL_CYC  = beam_pkg::line_cycles(DOTS_PER_LINE, CYC_PER_DOT, 1'b0);
    localparam int SHORT_CYC = beam_pkg::line_cycles(DOTS_PER_LINE, CYC_PER_DOT, 1'b1);
    localparam logic [HW-1:0] FULL_LAST  = HW'(FULL_CYC - 1);
    localparam logic [HW-1:0] SHORT_LAST = HW'(SHORT_CYC - 1);
    localparam logic [PW-1:0] PHASE_LAST = PW'(CYC_PER_DOT - 1);

    logic [PW-1:0] phase;
    logic [HW-1:0] last_cyc;

    always_comb begin
        last_cyc = short_line ? SHORT_LAST : FULL_LAST;
        eol      = (hcount == last_cyc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcount <= '0;
            dot    <= '0;
            phase  <= '0;
        end else if (eol) begin
            hcount <= '0;
            dot    <= '0;
            phase  <= '0;
        end else begin
            hcount <= hcount + 1'b1;
            if (phase == PHASE_LAST) begin
                phase <= '0;
                dot   <= dot + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/beam_frame_limits.sv
module beam_frame_limits #(
    parameter int LINES_A    = 262,
    parameter int LINES_B    = 312,
    parameter int SHORT_LINE = 240,
    parameter int VW         = 9
) (
    input  beam_pkg::frame_cfg_t cfg,
    input  logic [VW-1:0]        next_v,
    input  logic                 next_field,
    input  logic                 interlace_en,
    output logic [VW-1:0]        vlast,
    output logic                 short_next
);
    localparam logic [VW-1:0] SHORT_V = VW'(SHORT_LINE);

    always_comb begin
        vlast      = VW'(beam_pkg::frame_lines(LINES_A, LINES_B, cfg) - 1);
        short_next = !interlace_en && next_field && (next_v == SHORT_V);
    end

endmodule

// File: rtl/beam_vcounter.sv
module beam_vcounter #(
    parameter int LINES_A    = 262,
    parameter int LINES_B    = 312,
    parameter int SHORT_LINE = 240,
    parameter int VW         = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eol,
    input  logic          interlace_en,
    input  logic          region_sel,
    output logic [VW-1:0] vcount,
    output logic          field,
    output logic          frame_toggle,
    output logic          eof,
    output logic          short_line
);
    beam_pkg::frame_cfg_t cfg_q, cfg_next;
    logic [VW-1:0] vlast;
    logic [VW-1:0] next_v;
    logic          next_field;
    logic          short_next;

    beam_frame_limits #(
        .LINES_A    (LINES_A),
        .LINES_B    (LINES_B),
        .SHORT_LINE (SHORT_LINE),
        .VW         (VW)
    ) u_limits (
        .cfg          (cfg_q),
        .next_v       (next_v),
        .next_field   (next_field),
        .interlace_en (interlace_en),
        .vlast        (vlast),
        .short_next   (short_next)
    );

    always_comb begin
        eof        = eol && (vcount == vlast);
        next_v     = eof ? '0 : vcount + 1'b1;
        next_field = eof ? ~field : field;
        cfg_next   = cfg_q;
        if (eof) begin
            cfg_next.region = region_sel;
            cfg_next.extra  = interlace_en && !next_field;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vcount       <= '0;
            field        <= 1'b0;
            frame_toggle <= 1'b0;
            cfg_q.region <= region_sel;
            cfg_q.extra  <= 1'b0;
            short_line   <= 1'b0;
        end else if (eol) begin
            vcount     <= next_v;
            field      <= next_field;
            cfg_q      <= cfg_next;
            short_line <= short_next;
            if (eof) frame_toggle <= ~frame_toggle;
        end
    end

endmodule

// File: rtl/beam_raster_counter.sv
module beam_raster_counter #(
    parameter int CYC_PER_DOT   = 4,
    parameter int DOTS_PER_LINE = 341,
    parameter int LINES_A       = 262,
    parameter int LINES_B       = 312,
    parameter int SHORT_LINE    = 240,
    localparam int HW = $clog2(CYC_PER_DOT * DOTS_PER_LINE + 1),
    localparam int DW = $clog2(DOTS_PER_LINE + 1),
    localparam int VW = $clog2(LINES_B + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          interlace_en,
    input  logic          region_sel,
    output logic [HW-1:0] hcount,
    output logic [DW-1:0] dot,
    output logic [VW-1:0] vcount,
    output logic          field,
    output logic          eol,
    output logic          eof,
    output logic          frame_toggle
);
    logic short_line;

    beam_hcounter #(
        .CYC_PER_DOT   (CYC_PER_DOT),
        .DOTS_PER_LINE (DOTS_PER_LINE),
        .HW            (HW),
        .DW            (DW)
    ) u_h (
        .clk        (clk),
        .rst        (rst),
        .short_line (short_line),
        .hcount     (hcount),
        .dot        (dot),
        .eol        (eol)
    );

    beam_vcounter #(
        .LINES_A    (LINES_A),
        .LINES_B    (LINES_B),
        .SHORT_LINE (SHORT_LINE),
        .VW         (VW)
    ) u_v (
        .clk          (clk),
        .rst          (rst),
        .eol          (eol),
        .interlace_en (interlace_en),
        .region_sel   (region_sel),
        .vcount       (vcount),
        .field        (field),
        .frame_toggle (frame_toggle),
        .eof          (eof),
        .short_line   (short_line)
    );

endmodule

// File: rtl/beam_raster_checker.sv
module beam_raster_checker #(
    parameter int CYC_PER_DOT   = 4,
    parameter int DOTS_PER_LINE = 341,
    parameter int LINES_A       = 262,
    parameter int LINES_B       = 312,
    parameter int SHORT_LINE    = 240,
    parameter int HW            = 11,
    parameter int DW            = 9,
    parameter int VW            = 9
) (
    input logic          clk,
    input logic          rst,
    input logic [HW-1:0] hcount,
    input logic [DW-1:0] dot,
    input logic [VW-1:0] vcount,
    input logic          field,
    input logic          eol,
    input logic          eof,
    input logic          frame_toggle
);
    localparam logic [HW-1:0] SHORT_LAST = HW'((DOTS_PER_LINE - 1) * CYC_PER_DOT - 1);

    AST_DOT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        32'(dot) == 32'(hcount) / CYC_PER_DOT); // R2
    AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
        !eol |=> hcount == HW'($past(hcount) + 1)); // R2
    AST_EOL_PULSE: assert property (@(posedge clk) disable iff (rst)
        eol |=> !eol); // R3
    AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
        eol |=> (hcount == '0) && (dot == '0)); // R3
    AST_V_STEP: assert property (@(posedge clk) disable iff (rst)
        eol && !eof |=> vcount == VW'($past(vcount) + 1)); // R3
    AST_SHORT_WHERE: assert property (@(posedge clk) disable iff (rst)
        eol && (hcount == SHORT_LAST) |-> field && (vcount == VW'(SHORT_LINE))); // R4
    AST_EOF_IN_EOL: assert property (@(posedge clk) disable iff (rst)
        eof |-> eol); // R6
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        eof |=> (vcount == '0) && (field != $past(field))); // R6
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eof |=> $stable(field)); // R6
    AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (rst)
        eof |-> (vcount == VW'(LINES_A - 1)) || (vcount == VW'(LINES_A)) ||
                (vcount == VW'(LINES_B - 1)) || (vcount == VW'(LINES_B))); // R7
    AST_STATUS_FLIP: assert property (@(posedge clk) disable iff (rst)
        eof |=> frame_toggle != $past(frame_toggle)); // R8
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eof |=> $stable(frame_toggle)); // R8

endmodule

bind beam_raster_counter beam_raster_checker #(
    .CYC_PER_DOT   (CYC_PER_DOT),
    .DOTS_PER_LINE (DOTS_PER_LINE),
    .LINES_A       (LINES_A),
    .LINES_B       (LINES_B),
    .SHORT_LINE    (SHORT_LINE),
    .HW            (HW),
    .DW            (DW),
    .VW            (VW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hcount       (hcount),
    .dot          (dot),
    .vcount       (vcount),
    .field        (field),
    .eol          (eol),
    .eof          (eof),
    .frame_toggle (frame_toggle)
);

// File: tb/beam_raster_counter_tb.sv
module beam_raster_counter_tb;
    localparam int CPD   = 4;
    localparam int DOTS  = 12;
    localparam int LA    = 10;
    localparam int LB    = 13;
    localparam int SHORT = 6;
    localparam int HW = $clog2(CPD * DOTS + 1);
    localparam int DW = $clog2(DOTS + 1);
    localparam int VW = $clog2(LB + 2);
    localparam int FULL_LEN  = CPD * DOTS;
    localparam int SHORT_LEN = CPD * (DOTS - 1);

    typedef struct packed {
        bit il;
        bit rg;
    } vec_t;
    localparam vec_t VECS [4] = '{'{1'b0, 1'b0}, '{1'b1, 1'b0},
                                  '{1'b0, 1'b1}, '{1'b1, 1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic interlace_en = 1'b0;
    logic region_sel = 1'b0;
    logic [HW-1:0] hcount;
    logic [DW-1:0] dot;
    logic [VW-1:0] vcount;
    logic field, eol, eof, frame_toggle;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit exp_field = 1'b0;
    bit exp_stat = 1'b0;

    always #10 clk = ~clk;

    beam_raster_counter #(
        .CYC_PER_DOT   (CPD),
        .DOTS_PER_LINE (DOTS),
        .LINES_A       (LA),
        .LINES_B       (LB),
        .SHORT_LINE    (SHORT)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .interlace_en (interlace_en),
        .region_sel   (region_sel),
        .hcount       (hcount),
        .dot          (dot),
        .vcount       (vcount),
        .field        (field),
        .eol          (eol),
        .eof          (eof),
        .frame_toggle (frame_toggle)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs until the end of a frame; cyc0 is the number of that frame's
    // cycles already sampled. chg_line >= 0 drives new mode inputs after
    // that many lines have ended.
    task automatic run_frame(input bit do_chk, input int exp_lines,
                             input bit exp_short, input int cyc0,
                             input int chg_line, input bit chg_il,
                             input bit chg_rg);
        int cyc = cyc0;
        int lines = 0;
        int len;
        bit fin = 1'b0;
        while (!fin) begin
            @(negedge clk);
            cyc++;
            if (do_chk && eof && !eol) check("R6 eof without eol", 0, 1);
            if (eol) begin
                len = (exp_short && lines == SHORT) ? SHORT_LEN : FULL_LEN;
                if (do_chk) begin
                    check("R3 R4 R5 R9 line length", cyc, len);
                    check("R3 last hcount", int'(hcount), len - 1);
                    check("R2 last dot", int'(dot), len / CPD - 1);
                    check("R3 vcount", int'(vcount), lines);
                    check("R6 field", int'(field), int'(exp_field));
                    check("R8 status", int'(frame_toggle), int'(exp_stat));
                end
                lines++;
                cyc = 0;
                if (lines == chg_line) begin
                    interlace_en = chg_il;
                    region_sel = chg_rg;
                end
            end
            if (eof) begin
                if (do_chk) check("R6 R7 frame lines", lines, exp_lines);
                fin = 1'b1;
            end
            if (cyc > 2 * FULL_LEN) begin
                check("R3 missing eol", cyc, FULL_LEN);
                fin = 1'b1;
            end
        end
        exp_field = ~exp_field;
        exp_stat = ~exp_stat;
    endtask

    task automatic check_reset_state(input string req);
        check({req, " hcount"}, int'(hcount), 0);
        check({req, " dot"}, int'(dot), 0);
        check({req, " vcount"}, int'(vcount), 0);
        check({req, " field"}, int'(field), 0);
        check({req, " status"}, int'(frame_toggle), 0);
        check({req, " eol"}, int'(eol), 0);
    endtask

    function automatic int lines_for(input bit il, input bit rg, input bit f);
        return (rg ? LB : LA) + ((il && !f) ? 1 : 0);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1 reset");
        rst = 1'b0;
        // R1: first frame after reset, base lines, field 0, no short line
        run_frame(1'b1, LA, 1'b0, 1, -1, 1'b0, 1'b0);

        // Table of mode vectors: one settling frame, then two measured frames
        for (int i = 0; i < 4; i++) begin
            interlace_en = VECS[i].il;
            region_sel = VECS[i].rg;
            run_frame(1'b0, 0, 1'b0, 0, -1, 1'b0, 1'b0);
            for (int k = 0; k < 2; k++) begin
                run_frame(1'b1, lines_for(VECS[i].il, VECS[i].rg, exp_field),
                          !VECS[i].il && exp_field, 0, -1, 1'b0, 1'b0);
            end
        end

        // R7 R9: non-interlaced frame with field 1 selected at the wrap
        interlace_en = 1'b0;
        region_sel = 1'b0;
        run_frame(1'b0, 0, 1'b0, 0, -1, 1'b0, 1'b0);
        if (!exp_field) run_frame(1'b0, 0, 1'b0, 0, -1, 1'b0, 1'b0);
        // R7: mode change mid-frame keeps base lines; R9: line 6 starts with
        // interlace on, so it is full length although the frame began without
        run_frame(1'b1, LA, 1'b0, 0, 2, 1'b1, 1'b1);
        // R7: next frame uses the new region and interlace, field 0 -> extra
        run_frame(1'b1, lines_for(1'b1, 1'b1, exp_field), 1'b0, 0, -1, 1'b0, 1'b0);

        // R9: interlace dropped after line 6 starts; line 6 stays full length
        run_frame(1'b1, lines_for(1'b1, 1'b1, exp_field), 1'b0, 0, SHORT + 1, 1'b0, 1'b1);

        // R1: reset in mid-frame with interlace on and long region
        interlace_en = 1'b1;
        region_sel = 1'b1;
        repeat (70) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset_state("R1 mid-run reset");
        rst = 1'b0;
        exp_field = 1'b0;
        exp_stat = 1'b0;
        run_frame(1'b1, LB, 1'b0, 1, -1, 1'b0, 1'b0);
        run_frame(1'b1, LB, 1'b0, 0, -1, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule